// File: doc/BRIEF.md
# Mixed-Sign Byte Dot-Product Accumulator

This unit takes three vectors of equal width: an unsigned-byte operand, a signed-byte operand and an accumulator. It returns a new accumulator vector. The vectors are divided into independent 32-bit lanes.

Within a lane, the four unsigned bytes of the first operand are multiplied by the signed bytes in the same positions of the second operand. The four products are summed, and the sum is added to the accumulator lane. The addition wraps at 32 bits.

Operands enter through a valid/ready handshake and results leave through another. A parameter selects either a registered output stage or a purely combinational path. The unit sits in a vector execution pipe, downstream of decode and register read.

Top module: `mdot_accum`

## Requirements
- R1: Byte i of lane e occupies bits [32e+8i+7 : 32e+8i] of each operand vector. Byte 0 of lane 0 is at the least significant end.
- R2: Bytes of `in_ua` are zero-extended, so they are valued 0 to 255.
- R3: Bytes of `in_sb` are sign-extended, so they are valued -128 to 127. The four-product lane sum lies between -130560 and 129540.
- R4: Each output lane equals the input accumulator lane plus the sum of the four byte products of that lane.
- R5: The accumulator addition is modulo 2^32 and does not saturate.
- R6: Every lane is updated on every operation, independently of the other lanes, with no mask.
- R7: The lane count is `VLEN/32`, and `VLEN` must be a multiple of 32. The top lane occupies bits [VLEN-1 : VLEN-32].
- R8: With `PIPE=1`, an operand set accepted when `in_valid` and `in_ready` are both high at a clock edge makes `out_valid` high after that edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_acc` stays unchanged. Input changes during that time have no effect on the output.
- R10: With `PIPE=1`, `in_ready` is high when the stage is empty or `out_ready` is high. After reset, `out_valid` is low and `in_ready` is high.
- R11: With `PIPE=0`, `out_acc` is the combinational result of the current inputs, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Unit can take an operand set |
| in_ua | input | VLEN | Unsigned byte operand |
| in_sb | input | VLEN | Signed byte operand |
| in_acc | input | VLEN | Accumulator input |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_acc | output | VLEN | Updated accumulator |

## Verification
The hardest cases to reach are the extremes of the mixed-sign product and the 32-bit wrap. Uniform random bytes seldom give all four products at -32640, and they almost never place the accumulator where a carry crosses the sign boundary. Directed operand sets supply these cases: 255 against -128 in every byte, 255 against 127 added to 0x7FFFFFF0, and the minimum sum added to 0x80000010. A one-hot byte pattern confirms slicing in every lane, including the top lane. Random sets with a fixed seed fill in the rest. Each transaction is held under back-pressure while the inputs are scrambled, which confirms that the held result does not change.

// File: rtl/mdot_pkg.sv
package mdot_pkg;

  localparam int LANE_W = 32;
  localparam int BYTE_W = 8;
  localparam int SUBS   = LANE_W / BYTE_W;
  localparam int PROD_W = 17;
  localparam int SUM_W  = 19;

  localparam int SUM_MIN = -130560;
  localparam int SUM_MAX = 129540;

  typedef logic [LANE_W-1:0]        lane_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [SUM_W-1:0]  dsum_t;

  // unsigned byte times signed byte, exact in 17 bits
  function automatic prod_t mixed_mul(input logic [7:0] u, input logic [7:0] s);
    logic signed [8:0]  ue;
    logic signed [8:0]  se;
    logic signed [17:0] full;
    ue   = {1'b0, u};
    se   = {s[7], s};
    full = ue * se;
    return full[PROD_W-1:0];
  endfunction

  // four-way reduction of one lane
  function automatic dsum_t lane_dot(input lane_t ua, input lane_t sb);
    dsum_t acc;
    prod_t p;
    acc = '0;
    for (int i = 0; i < SUBS; i++) begin
      p   = mixed_mul(ua[BYTE_W*i +: BYTE_W], sb[BYTE_W*i +: BYTE_W]);
      acc = acc + {{(SUM_W-PROD_W){p[PROD_W-1]}}, p};
    end
    return acc;
  endfunction

  // wrapping 32-bit accumulate of a widened lane sum
  function automatic lane_t lane_acc(input lane_t acc, input dsum_t d);
    return acc + {{(LANE_W-SUM_W){d[SUM_W-1]}}, d};
  endfunction

endpackage

// File: rtl/mdot_lane.sv
module mdot_lane
  import mdot_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  lane_t ua,
  input  lane_t sb,
  input  lane_t acc_in,
  output lane_t acc_out
);

  dsum_t dot_sum;

  always_comb begin
    dot_sum = lane_dot(ua, sb);
    acc_out = lane_acc(acc_in, dot_sum);
  end

  AST_DOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(dot_sum) >= SUM_MIN) && (int'(dot_sum) <= SUM_MAX)); // R3

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (ua == '0) |-> (acc_out == acc_in)); // R4

endmodule

// File: rtl/mdot_stage.sv
module mdot_stage #(
  parameter int W    = 128,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  generate
    if (PIPE) begin : g_reg
      logic         full_q;
      logic [W-1:0] data_q;
      logic         take;
      logic         drain;

      assign in_ready  = !full_q || out_ready;
      assign take      = in_valid && in_ready;
      assign drain     = full_q && out_ready;
      assign out_valid = full_q;
      assign out_data  = data_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          data_q <= '0;
        end else begin
          if (take) begin
            full_q <= 1'b1;
            data_q <= in_data;
          end else if (drain) begin
            full_q <= 1'b0;
          end
        end
      end

      AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid); // R8

      AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

      AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R10
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate

endmodule

// File: rtl/mdot_accum.sv
module mdot_accum
  import mdot_pkg::*;
#(
  parameter int VLEN = 128,
  parameter bit PIPE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VLEN-1:0] in_ua,
  input  logic [VLEN-1:0] in_sb,
  input  logic [VLEN-1:0] in_acc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VLEN-1:0] out_acc
);

  localparam int LANES = VLEN / LANE_W;

  initial begin
    AST_VLEN_MULT: assert ((VLEN % LANE_W) == 0 && VLEN > 0); // R7
  end

  logic [VLEN-1:0] lane_res;

  generate
    for (genvar e = 0; e < LANES; e++) begin : g_lane
      mdot_lane u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .ua      (in_ua [LANE_W*e +: LANE_W]),
        .sb      (in_sb [LANE_W*e +: LANE_W]),
        .acc_in  (in_acc[LANE_W*e +: LANE_W]),
        .acc_out (lane_res[LANE_W*e +: LANE_W])
      );
    end
  endgenerate

  mdot_stage #(.W(VLEN), .PIPE(PIPE)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (lane_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_acc)
  );

endmodule

// File: tb/mdot_accum_tb_top.sv
module mdot_accum_tb_top;

  localparam int VLEN  = 128;
  localparam int LANES = VLEN / 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [VLEN-1:0] in_ua = '0, in_sb = '0, in_acc = '0;
  logic [VLEN-1:0] out_acc;
  logic in_ready_c, out_valid_c;
  logic [VLEN-1:0] out_acc_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mdot_accum #(.VLEN(VLEN), .PIPE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ua(in_ua), .in_sb(in_sb), .in_acc(in_acc),
    .out_valid(out_valid), .out_ready(out_ready), .out_acc(out_acc));

  mdot_accum #(.VLEN(VLEN), .PIPE(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_c),
    .in_ua(in_ua), .in_sb(in_sb), .in_acc(in_acc),
    .out_valid(out_valid_c), .out_ready(1'b1), .out_acc(out_acc_c));

  function automatic logic [VLEN-1:0] ref_model(input logic [VLEN-1:0] a,
                                                 input logic [VLEN-1:0] b,
                                                 input logic [VLEN-1:0] c);
    logic [VLEN-1:0] r;
    for (int e = 0; e < LANES; e++) begin
      int s;
      s = int'(c[32*e +: 32]);
      for (int i = 0; i < 4; i++) begin
        int x, y;
        x = int'({24'd0, a[32*e+8*i +: 8]});
        y = int'({{24{b[32*e+8*i+7]}}, b[32*e+8*i +: 8]});
        s = s + x * y;
      end
      r[32*e +: 32] = s;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [VLEN-1:0] act,
                     input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                         input logic [VLEN-1:0] c, input string tag);
    logic [VLEN-1:0] exp;
    exp = ref_model(a, b, c);
    @(negedge clk);
    in_ua = a; in_sb = b; in_acc = c; in_valid = 1'b1; out_ready = 1'b0;
    #1;
    chk(out_acc_c == exp, {"R11 comb ", tag}, out_acc_c, exp);
    chk(out_valid_c == 1'b1, "R11 valid pass", VLEN'(out_valid_c), VLEN'(1));
    chk(in_ready == 1'b1, "R10 ready empty", VLEN'(in_ready), VLEN'(1));
    @(negedge clk);
    in_valid = 1'b0;
    in_ua = {4{$urandom()}}; in_sb = {4{$urandom()}}; in_acc = {4{$urandom()}};
    chk(out_valid == 1'b1, "R8 valid next", VLEN'(out_valid), VLEN'(1));
    chk(out_acc == exp, {"R4 ", tag}, out_acc, exp);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_acc == exp, "R9 hold", out_acc, exp);
    chk(in_ready == 1'b0, "R10 ready full", VLEN'(in_ready), VLEN'(0));
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R10 ready drain", VLEN'(in_ready), VLEN'(1));
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 drained", VLEN'(out_valid), VLEN'(0));
    out_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset valid", VLEN'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 reset ready", VLEN'(in_ready), VLEN'(1));

    run_txn('0, '0, '0, "R4 all zero");
    run_txn({VLEN/8{8'hFF}}, {VLEN/8{8'h80}}, '0, "R2 R3 255x-128");
    run_txn({VLEN/8{8'hFF}}, {VLEN/8{8'h7F}}, {LANES{32'h7FFF_FFF0}}, "R5 wrap up");
    run_txn({VLEN/8{8'hFF}}, {VLEN/8{8'h80}}, {LANES{32'h8000_0010}}, "R5 wrap down");
    // one-hot byte per lane: lane e uses byte e mod 4 (R1, R6, R7 top lane)
    begin
      logic [VLEN-1:0] a, b;
      a = '0; b = '0;
      for (int e = 0; e < LANES; e++) begin
        a[32*e + 8*(e%4) +: 8] = 8'(e + 3);
        b[32*e + 8*(e%4) +: 8] = 8'(8'hF0 + e);
      end
      run_txn(a, b, {32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444},
              "R1 R6 R7 slicing");
    end
    for (int k = 0; k < 40; k++) begin
      run_txn({$urandom(), $urandom(), $urandom(), $urandom()},
              {$urandom(), $urandom(), $urandom(), $urandom()},
              {$urandom(), $urandom(), $urandom(), $urandom()}, "R4 random");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule